// File: doc/BRIEF.md
# Two-Channel Priority Memory Protection Checker

The block judges every data access and every instruction fetch against access rights set up by software. Two address windows, called channels, each hold a base address, a limit address, an enable bit and four rights bits: supervisor read/execute, supervisor write, user read/execute and user write. A data access and a fetch can arrive in the same cycle. Each is looked up separately against the same windows. The matching channel with the highest number supplies the rights. When no channel matches, a separate default rights register applies. A denied access raises a one-cycle trap request together with a strobe that forces the core into supervisor mode. A cause bit tells whether the denied access was a data access or a fetch.

Software programs the windows through a simple write port. Writes take effect only while the core runs in supervisor or emulation mode, so code in user mode cannot widen its own rights. After reset no channel is enabled and the default register grants everything, so an unconfigured system never traps.

The trap reporter is a two-state machine. `RPT_IDLE` reports at most one new denial per cycle, and a data denial takes precedence. It moves to `RPT_FETCH_PEND` when a data denial and a fetch denial occur in the same cycle, which defers the fetch report. In `RPT_FETCH_PEND` a new data denial is reported and the machine stays in that state. Otherwise the deferred fetch is reported. The machine then returns to `RPT_IDLE`, or stays in `RPT_FETCH_PEND` when another fetch denial has just occurred.

Top module: `mpu_checker`

## Requirements
- R1: After reset all channels are disabled and the default rights grant every access. No access of any kind in any mode raises `trap_req`.
- R2: A channel matches an address when its enable bit is set and base <= address <= limit. Both ends of the window are included.
- R3: When both channels match an address, only channel 1's rights apply.
- R4: When no enabled channel matches, the default register applies. Its layout is bit 0 supervisor read/execute, bit 1 supervisor write, bit 2 user read/execute and bit 3 user write.
- R5: A data access in supervisor mode (`mode_sv`=1) checks supervisor read or supervisor write. In any other mode it checks user read or user write. `oa_write`=1 selects a write check and 0 selects a read check.
- R6: A fetch checks only the supervisor or user read/execute right for the current mode. The write rights have no effect on fetches.
- R7: Config writes take effect only when `mode_sv` or `mode_emu` is high, and are ignored otherwise. The map is: address 2n = base of channel n, 2n+1 = limit of channel n, 4 = control, 5 = default rights. The control fields are [1:0] enable, [3:2] supervisor read/execute, [5:4] supervisor write, [7:6] user read/execute and [9:8] user write. Bit n of each field belongs to channel n.
- R8: A denied access with its valid strobe high raises `trap_req` and `force_sv` for exactly one cycle, on the clock edge that samples the access. A denied address presented with its valid strobe low raises nothing.
- R9: When a data denial and a fetch denial occur in the same cycle, the data trap (`trap_cause`=0) is reported first. The fetch trap (`trap_cause`=1) follows one cycle later.
- R10: A data access and a fetch in the same cycle are matched independently. Each may hit a different channel, and a denial on one side alone is reported with that side's cause.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Config write strobe |
| cfg_addr | input | CFG_AW | Config register address |
| cfg_wdata | input | AW | Config write data |
| mode_sv | input | 1 | Core is in supervisor mode |
| mode_emu | input | 1 | Core is in emulation mode |
| oa_valid | input | 1 | Data access valid |
| oa_addr | input | AW | Data access address |
| oa_write | input | 1 | Data access is a write (1) or a read (0) |
| ia_valid | input | 1 | Instruction fetch valid |
| ia_addr | input | AW | Instruction fetch address |
| trap_req | output | 1 | One-cycle protection trap request |
| trap_cause | output | 1 | 0 = data denial, 1 = fetch denial |
| force_sv | output | 1 | Strobe forcing supervisor mode, high together with trap_req |

## Verification
The bench drives an access on a falling edge. The trap outputs register on the following rising edge, so the checks read them on the next falling edge, one cycle after the access. A config write is also driven on a falling edge and takes effect on the next rising edge. Every access after a write is therefore judged against the new settings. For the simultaneous case, the bench checks the data trap one cycle after the access and the deferred fetch trap at the falling edge after that. One more sample confirms that the pulse has dropped.

// File: rtl/mpu_pkg.sv
package mpu_pkg;

    // Rights bits; sr is bit 0 so the default register layout is {uw, ur, sw, sr}
    typedef struct packed {
        logic uw;
        logic ur;
        logic sw;
        logic sr;
    } perm_t;

    typedef enum logic {
        RPT_IDLE       = 1'b0,
        RPT_FETCH_PEND = 1'b1
    } rpt_state_t;

    localparam logic CAUSE_DATA  = 1'b0;
    localparam logic CAUSE_FETCH = 1'b1;

endpackage

// File: rtl/mpu_cfg_regs.sv
module mpu_cfg_regs
    import mpu_pkg::*;
#(
    parameter int AW     = 32,
    parameter int NCH    = 2,
    parameter int CFG_AW = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     we,
    input  logic [CFG_AW-1:0]        waddr,
    input  logic [AW-1:0]            wdata,
    input  logic                     mode_sv,
    input  logic                     mode_emu,
    output logic [NCH-1:0][AW-1:0]   base_o,
    output logic [NCH-1:0][AW-1:0]   limit_o,
    output logic [NCH-1:0]           en_o,
    output logic [NCH-1:0]           srx_o,
    output logic [NCH-1:0]           sw_o,
    output logic [NCH-1:0]           urx_o,
    output logic [NCH-1:0]           uw_o,
    output perm_t                    dflt_o
);

    localparam int CTRL_IDX = 2 * NCH;
    localparam int DFLT_IDX = 2 * NCH + 1;
    localparam int CTRL_W   = 5 * NCH;

    logic              wr_ok;
    logic [CTRL_W-1:0] ctrl_q;

    // Writes are honoured only in a privileged mode
    assign wr_ok = we & (mode_sv | mode_emu);

    for (genvar g = 0; g < NCH; g++) begin : g_chan
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                base_o[g]  <= '0;
                limit_o[g] <= '0;
            end else if (wr_ok) begin
                if (waddr == CFG_AW'(2 * g))
                    base_o[g] <= wdata;
                if (waddr == CFG_AW'(2 * g + 1))
                    limit_o[g] <= wdata;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            dflt_o <= '{uw: 1'b1, ur: 1'b1, sw: 1'b1, sr: 1'b1};
        end else if (wr_ok) begin
            if (waddr == CFG_AW'(CTRL_IDX))
                ctrl_q <= wdata[CTRL_W-1:0];
            if (waddr == CFG_AW'(DFLT_IDX))
                dflt_o <= perm_t'(wdata[3:0]);
        end
    end

    assign en_o  = ctrl_q[NCH-1:0];
    assign srx_o = ctrl_q[2*NCH-1:NCH];
    assign sw_o  = ctrl_q[3*NCH-1:2*NCH];
    assign urx_o = ctrl_q[4*NCH-1:3*NCH];
    assign uw_o  = ctrl_q[5*NCH-1:4*NCH];

endmodule

// File: rtl/mpu_region_match.sv
module mpu_region_match #(
    parameter int AW  = 32,
    parameter int NCH = 2
) (
    input  logic [AW-1:0]           addr,
    input  logic [NCH-1:0][AW-1:0]  base,
    input  logic [NCH-1:0][AW-1:0]  limit,
    input  logic [NCH-1:0]          en,
    output logic [NCH-1:0]          hit
);

    for (genvar g = 0; g < NCH; g++) begin : g_cmp
        assign hit[g] = en[g] && (addr >= base[g]) && (addr <= limit[g]);
    end

endmodule

// File: rtl/mpu_perm_select.sv
module mpu_perm_select
    import mpu_pkg::*;
#(
    parameter int NCH = 2
) (
    input  logic [NCH-1:0] hit,
    input  logic [NCH-1:0] srx,
    input  logic [NCH-1:0] sw,
    input  logic [NCH-1:0] urx,
    input  logic [NCH-1:0] uw,
    input  perm_t          dflt,
    input  logic           priv_sv,
    input  logic           is_write,
    output logic           allowed
);

    perm_t eff;

    // Ascending scan: a higher-numbered hit overrides a lower one
    always_comb begin
        eff = dflt;
        for (int i = 0; i < NCH; i++) begin
            if (hit[i]) begin
                eff.sr = srx[i];
                eff.sw = sw[i];
                eff.ur = urx[i];
                eff.uw = uw[i];
            end
        end
    end

    always_comb begin
        unique case ({priv_sv, is_write})
            2'b11:   allowed = eff.sw;
            2'b10:   allowed = eff.sr;
            2'b01:   allowed = eff.uw;
            default: allowed = eff.ur;
        endcase
    end

endmodule

// File: rtl/mpu_checker.sv
module mpu_checker
    import mpu_pkg::*;
#(
    parameter int AW     = 32,
    parameter int NCH    = 2,
    parameter int CFG_AW = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [AW-1:0]     cfg_wdata,
    input  logic              mode_sv,
    input  logic              mode_emu,
    input  logic              oa_valid,
    input  logic [AW-1:0]     oa_addr,
    input  logic              oa_write,
    input  logic              ia_valid,
    input  logic [AW-1:0]     ia_addr,
    output logic              trap_req,
    output logic              trap_cause,
    output logic              force_sv
);

    logic [NCH-1:0][AW-1:0] ch_base;
    logic [NCH-1:0][AW-1:0] ch_limit;
    logic [NCH-1:0]         ch_en;
    logic [NCH-1:0]         ch_srx;
    logic [NCH-1:0]         ch_sw;
    logic [NCH-1:0]         ch_urx;
    logic [NCH-1:0]         ch_uw;
    perm_t                  dflt_perm;

    logic [NCH-1:0] oa_hit;
    logic [NCH-1:0] ia_hit;
    logic           oa_ok;
    logic           ia_ok;
    logic           oa_viol;
    logic           ia_viol;

    rpt_state_t state_q;
    rpt_state_t state_d;
    logic       rpt_vld_d;
    logic       rpt_cause_d;
    logic       fetch_pend;

    mpu_cfg_regs #(.AW(AW), .NCH(NCH), .CFG_AW(CFG_AW)) i_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (cfg_we),
        .waddr    (cfg_addr),
        .wdata    (cfg_wdata),
        .mode_sv  (mode_sv),
        .mode_emu (mode_emu),
        .base_o   (ch_base),
        .limit_o  (ch_limit),
        .en_o     (ch_en),
        .srx_o    (ch_srx),
        .sw_o     (ch_sw),
        .urx_o    (ch_urx),
        .uw_o     (ch_uw),
        .dflt_o   (dflt_perm)
    );

    mpu_region_match #(.AW(AW), .NCH(NCH)) i_oa_match (
        .addr  (oa_addr),
        .base  (ch_base),
        .limit (ch_limit),
        .en    (ch_en),
        .hit   (oa_hit)
    );

    mpu_region_match #(.AW(AW), .NCH(NCH)) i_ia_match (
        .addr  (ia_addr),
        .base  (ch_base),
        .limit (ch_limit),
        .en    (ch_en),
        .hit   (ia_hit)
    );

    mpu_perm_select #(.NCH(NCH)) i_oa_perm (
        .hit      (oa_hit),
        .srx      (ch_srx),
        .sw       (ch_sw),
        .urx      (ch_urx),
        .uw       (ch_uw),
        .dflt     (dflt_perm),
        .priv_sv  (mode_sv),
        .is_write (oa_write),
        .allowed  (oa_ok)
    );

    // Fetches are always judged as reads, so the write rights never matter
    mpu_perm_select #(.NCH(NCH)) i_ia_perm (
        .hit      (ia_hit),
        .srx      (ch_srx),
        .sw       (ch_sw),
        .urx      (ch_urx),
        .uw       (ch_uw),
        .dflt     (dflt_perm),
        .priv_sv  (mode_sv),
        .is_write (1'b0),
        .allowed  (ia_ok)
    );

    assign oa_viol    = oa_valid & ~oa_ok;
    assign ia_viol    = ia_valid & ~ia_ok;
    assign fetch_pend = (state_q == RPT_FETCH_PEND);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= RPT_IDLE;
        else
            state_q <= state_d;
    end

    // Next state and report selection
    always_comb begin
        state_d     = state_q;
        rpt_vld_d   = 1'b0;
        rpt_cause_d = CAUSE_DATA;
        unique case (state_q)
            RPT_IDLE: begin
                if (oa_viol) begin
                    rpt_vld_d = 1'b1;
                    if (ia_viol)
                        state_d = RPT_FETCH_PEND;
                end else if (ia_viol) begin
                    rpt_vld_d   = 1'b1;
                    rpt_cause_d = CAUSE_FETCH;
                end
            end
            RPT_FETCH_PEND: begin
                rpt_vld_d = 1'b1;
                if (!oa_viol) begin
                    rpt_cause_d = CAUSE_FETCH;
                    state_d     = ia_viol ? RPT_FETCH_PEND : RPT_IDLE;
                end
            end
            default: state_d = RPT_IDLE;
        endcase
    end

    // Registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            trap_req   <= 1'b0;
            trap_cause <= CAUSE_DATA;
            force_sv   <= 1'b0;
        end else begin
            trap_req   <= rpt_vld_d;
            trap_cause <= rpt_vld_d ? rpt_cause_d : CAUSE_DATA;
            force_sv   <= rpt_vld_d;
        end
    end

endmodule

// File: rtl/mpu_checker_sva.sv
module mpu_checker_sva
    import mpu_pkg::*;
#(
    parameter int AW  = 32,
    parameter int NCH = 2
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   cfg_we,
    input logic                   mode_sv,
    input logic                   mode_emu,
    input logic                   oa_valid,
    input logic                   ia_valid,
    input logic                   oa_viol,
    input logic                   fetch_pend,
    input logic                   trap_req,
    input logic                   trap_cause,
    input logic                   force_sv,
    input logic [NCH-1:0]         ch_en,
    input logic [NCH-1:0][AW-1:0] ch_base,
    input perm_t                  dflt_perm
);

    // R7
    cfg_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && !mode_sv && !mode_emu) |=>
            ($stable(ch_en) && $stable(ch_base) && $stable(dflt_perm)));

    // R8
    sv_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req == force_sv);

    // R8
    trap_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req |-> $past(oa_valid || ia_valid || fetch_pend));

    // R9
    data_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_req && trap_cause) |-> !$past(oa_viol));

    // R5
    data_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_req && !trap_cause) |-> $past(oa_viol));

endmodule

bind mpu_checker mpu_checker_sva #(.AW(AW), .NCH(NCH)) i_mpu_sva (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_we     (cfg_we),
    .mode_sv    (mode_sv),
    .mode_emu   (mode_emu),
    .oa_valid   (oa_valid),
    .ia_valid   (ia_valid),
    .oa_viol    (oa_viol),
    .fetch_pend (fetch_pend),
    .trap_req   (trap_req),
    .trap_cause (trap_cause),
    .force_sv   (force_sv),
    .ch_en      (ch_en),
    .ch_base    (ch_base),
    .dflt_perm  (dflt_perm)
);

// File: tb/test_mpu_checker.sv
module test_mpu_checker;

    localparam int AW     = 32;
    localparam int CFG_AW = 3;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cfg_we = 1'b0;
    logic [CFG_AW-1:0] cfg_addr = '0;
    logic [AW-1:0]     cfg_wdata = '0;
    logic              mode_sv = 1'b1;
    logic              mode_emu = 1'b0;
    logic              oa_valid = 1'b0;
    logic [AW-1:0]     oa_addr = '0;
    logic              oa_write = 1'b0;
    logic              ia_valid = 1'b0;
    logic [AW-1:0]     ia_addr = '0;
    logic              trap_req;
    logic              trap_cause;
    logic              force_sv;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    mpu_checker #(.AW(AW), .NCH(2), .CFG_AW(CFG_AW)) i_mpu_checker (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_we     (cfg_we),
        .cfg_addr   (cfg_addr),
        .cfg_wdata  (cfg_wdata),
        .mode_sv    (mode_sv),
        .mode_emu   (mode_emu),
        .oa_valid   (oa_valid),
        .oa_addr    (oa_addr),
        .oa_write   (oa_write),
        .ia_valid   (ia_valid),
        .ia_addr    (ia_addr),
        .trap_req   (trap_req),
        .trap_cause (trap_cause),
        .force_sv   (force_sv)
    );

    function automatic logic [AW-1:0] ctrl_word(input logic [1:0] en, srx, sw, urx, uw);
        return AW'({uw, urx, sw, srx, en});
    endfunction

    task automatic chk(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0b expected=%0b", tag, act, exp);
        end
    endtask

    // Sample the registered trap outputs (called on a falling edge)
    task automatic expect_trap(input string tag, input logic req, input logic cause);
        chk({tag, " trap_req"}, trap_req, req);
        chk({tag, " force_sv"}, force_sv, req);
        if (req) chk({tag, " trap_cause"}, trap_cause, cause);
    endtask

    task automatic cfg_write(input logic [CFG_AW-1:0] a, input logic [AW-1:0] d);
        cfg_we    = 1'b1;
        cfg_addr  = a;
        cfg_wdata = d;
        @(negedge clk);
        cfg_we    = 1'b0;
    endtask

    task automatic access(input logic ov, input logic [AW-1:0] oa, input logic ow,
                          input logic iv, input logic [AW-1:0] ia);
        oa_valid = ov;
        oa_addr  = oa;
        oa_write = ow;
        ia_valid = iv;
        ia_addr  = ia;
        @(negedge clk);
        oa_valid = 1'b0;
        ia_valid = 1'b0;
    endtask

    task automatic setup_windows(input logic [AW-1:0] b0, l0, b1, l1);
        mode_sv = 1'b1;
        cfg_write(3'd0, b0);
        cfg_write(3'd1, l0);
        cfg_write(3'd2, b1);
        cfg_write(3'd3, l1);
    endtask

    task automatic t_reset;
        expect_trap("R1 reset", 1'b0, 1'b0);
        mode_sv = 1'b0;
        access(1'b1, 32'h0000_0150, 1'b1, 1'b1, 32'h0000_0150);
        expect_trap("R1 user write+fetch", 1'b0, 1'b0);
        mode_sv = 1'b1;
        access(1'b1, 32'hFFFF_FFFF, 1'b0, 1'b1, 32'h0);
        expect_trap("R1 sv read+fetch", 1'b0, 1'b0);
    endtask

    task automatic t_default;
        mode_sv = 1'b1;
        cfg_write(3'd5, 32'h0000_0003);   // supervisor rights only
        mode_sv = 1'b0;
        access(1'b1, 32'h0000_0040, 1'b0, 1'b0, '0);
        expect_trap("R4 default user read denied", 1'b1, 1'b0);
        mode_sv = 1'b1;
        access(1'b1, 32'h0000_0040, 1'b1, 1'b0, '0);
        expect_trap("R4 default sv write allowed", 1'b0, 1'b0);
        cfg_write(3'd5, 32'h0000_000F);
    endtask

    task automatic t_range;
        setup_windows(32'h100, 32'h1FF, 32'h180, 32'h27F);
        cfg_write(3'd4, ctrl_word(2'b01, 2'b11, 2'b11, 2'b00, 2'b00));
        mode_sv = 1'b0;
        access(1'b1, 32'h100, 1'b0, 1'b0, '0);
        expect_trap("R2 base inclusive", 1'b1, 1'b0);
        access(1'b1, 32'h1FF, 1'b0, 1'b0, '0);
        expect_trap("R2 limit inclusive", 1'b1, 1'b0);
        access(1'b1, 32'h0FF, 1'b0, 1'b0, '0);
        expect_trap("R2 below base", 1'b0, 1'b0);
        access(1'b1, 32'h200, 1'b0, 1'b0, '0);
        expect_trap("R2 above limit (ch1 disabled)", 1'b0, 1'b0);
    endtask

    task automatic t_priority;
        mode_sv = 1'b1;
        cfg_write(3'd4, ctrl_word(2'b11, 2'b11, 2'b11, 2'b01, 2'b01));
        mode_sv = 1'b0;
        access(1'b1, 32'h1A0, 1'b0, 1'b0, '0);
        expect_trap("R3 overlap ch1 denies", 1'b1, 1'b0);
        access(1'b1, 32'h150, 1'b0, 1'b0, '0);
        expect_trap("R3 ch0 only allows", 1'b0, 1'b0);
        mode_sv = 1'b1;
        cfg_write(3'd4, ctrl_word(2'b11, 2'b11, 2'b11, 2'b10, 2'b10));
        mode_sv = 1'b0;
        access(1'b1, 32'h1A0, 1'b0, 1'b0, '0);
        expect_trap("R3 overlap ch1 allows", 1'b0, 1'b0);
        access(1'b1, 32'h150, 1'b0, 1'b0, '0);
        expect_trap("R3 ch0 only denies", 1'b1, 1'b0);
    endtask

    task automatic t_data_fields;
        mode_sv = 1'b1;
        cfg_write(3'd4, ctrl_word(2'b01, 2'b01, 2'b00, 2'b00, 2'b01));
        access(1'b1, 32'h120, 1'b0, 1'b0, '0);
        expect_trap("R5 sv read", 1'b0, 1'b0);
        access(1'b1, 32'h120, 1'b1, 1'b0, '0);
        expect_trap("R5 sv write", 1'b1, 1'b0);
        mode_sv = 1'b0;
        access(1'b1, 32'h120, 1'b0, 1'b0, '0);
        expect_trap("R5 user read", 1'b1, 1'b0);
        access(1'b1, 32'h120, 1'b1, 1'b0, '0);
        expect_trap("R5 user write", 1'b0, 1'b0);
    endtask

    task automatic t_fetch;
        // same config: srx=1, sw=0, urx=0, uw=1 on ch0
        mode_sv = 1'b1;
        access(1'b0, '0, 1'b0, 1'b1, 32'h130);
        expect_trap("R6 sv fetch allowed", 1'b0, 1'b0);
        mode_sv = 1'b0;
        access(1'b0, '0, 1'b0, 1'b1, 32'h130);
        expect_trap("R6 user fetch denied despite uw", 1'b1, 1'b1);
        mode_sv = 1'b1;
        cfg_write(3'd4, ctrl_word(2'b01, 2'b00, 2'b01, 2'b01, 2'b00));
        access(1'b0, '0, 1'b0, 1'b1, 32'h130);
        expect_trap("R6 sv fetch denied despite sw", 1'b1, 1'b1);
        mode_sv = 1'b0;
        access(1'b0, '0, 1'b0, 1'b1, 32'h130);
        expect_trap("R6 user fetch allowed without uw", 1'b0, 1'b0);
    endtask

    task automatic t_lock;
        mode_sv = 1'b1;
        cfg_write(3'd4, '0);
        mode_sv  = 1'b0;
        mode_emu = 1'b0;
        cfg_write(3'd4, ctrl_word(2'b01, 2'b00, 2'b00, 2'b00, 2'b00));
        cfg_write(3'd5, 32'h0);
        access(1'b1, 32'h150, 1'b0, 1'b0, '0);
        expect_trap("R7 user writes ignored", 1'b0, 1'b0);
        mode_emu = 1'b1;
        cfg_write(3'd4, ctrl_word(2'b01, 2'b00, 2'b00, 2'b00, 2'b00));
        mode_emu = 1'b0;
        access(1'b1, 32'h150, 1'b0, 1'b0, '0);
        expect_trap("R7 emulation write applied", 1'b1, 1'b0);
    endtask

    task automatic t_pulse;
        // ch0 still denies everything at 0x100..0x1FF
        mode_sv = 1'b0;
        access(1'b1, 32'h150, 1'b1, 1'b0, '0);
        expect_trap("R8 pulse high", 1'b1, 1'b0);
        @(negedge clk);
        expect_trap("R8 pulse one cycle", 1'b0, 1'b0);
        access(1'b0, 32'h150, 1'b1, 1'b0, 32'h150);
        expect_trap("R8 no valid no trap", 1'b0, 1'b0);
    endtask

    task automatic t_both;
        mode_sv = 1'b0;
        access(1'b1, 32'h150, 1'b0, 1'b1, 32'h160);
        expect_trap("R9 data first", 1'b1, 1'b0);
        @(negedge clk);
        expect_trap("R9 fetch second", 1'b1, 1'b1);
        @(negedge clk);
        expect_trap("R9 then idle", 1'b0, 1'b0);
    endtask

    task automatic t_indep;
        setup_windows(32'h100, 32'h1FF, 32'h300, 32'h3FF);
        cfg_write(3'd4, ctrl_word(2'b11, 2'b11, 2'b11, 2'b10, 2'b10));
        cfg_write(3'd5, 32'h0000_000F);
        mode_sv = 1'b0;
        access(1'b1, 32'h350, 1'b0, 1'b1, 32'h150);
        expect_trap("R10 fetch-only denial", 1'b1, 1'b1);
        @(negedge clk);
        expect_trap("R10 no extra report", 1'b0, 1'b0);
        access(1'b1, 32'h150, 1'b1, 1'b1, 32'h350);
        expect_trap("R10 data-only denial", 1'b1, 1'b0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_default();
        t_range();
        t_priority();
        t_data_fields();
        t_fetch();
        t_lock();
        t_pulse();
        t_both();
        t_indep();
        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule